// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block is a 16-bit up-counting capture timer. It measures the time between chosen edges of an external signal. The counter advances once for each strobe of the selected count-enable source. When an effective edge arrives on the measured input, the running count is copied into a result register and the counter starts again from zero. Software selects one of three edge schemes:

- falling edge to falling edge, which gives the period;
- rising edge to rising edge, which also gives the period;
- every edge in either direction, which gives the high and low widths.

Software then starts the timer and reads each completed measurement from the result register. An interrupt request pulse reports each finished measurement and each counter overflow. The block does not request an interrupt on the first edge after start, because no full interval has been timed yet. A sticky overflow flag records a wrap of the counter. Software can clear the flag only through a later mode-register write, and only while the timer runs.

The register port is a plain single-cycle write and combinational read port. It is always ready and never applies back-pressure. Each completed measurement leaves through the result register and the interrupt pulse, not through a stream handshake. Software that misses an interrupt loses that result when the next effective edge overwrites it.

Top module: `pulse_capture_timer`

## Requirements
- R1: While running, the counter adds one for each cycle in which the selected strobe `tick_en[src]` is high. `src` is mode bits [7:6]: 00, 01, 10 and 11 select strobes 0, 1, 2 and 3. The other strobes have no effect.
- R2: On an effective edge while running, the result register takes the current count and the counter becomes 0 on the same clock edge.
- R3: Mode bits [3:2] pick the effective edges. 00 selects falling edges, 01 selects rising edges and 10 selects both directions. With 11, no edge is effective, so nothing is captured and no interrupt is raised.
- R4: After counting starts, the first effective edge captures but raises no interrupt. Each later effective edge raises `irq` for one cycle.
- R5: A tick that finds the count at 0xFFFF wraps the counter to 0, sets `ovf_flag` and raises `irq`.
- R6: Software cannot set `ovf_flag`. A mode-register write clears it only when all three of these hold:
  - the start bit is 1;
  - a running tick has occurred after the flag was set;
  - the write is in a cycle later than that tick.
  If a new overflow arrives in the same cycle as a clearing write, the flag stays set.
- R7: Address 2 reads the result register. A write to address 2 changes neither the result nor the counter.
- R8: Counting runs only while the start bit (address 1, bit 0) is 1 and mode bits [1:0] equal 10. At the transition into the running state, the counter clears and first-edge suppression is re-armed. While stopped, edges and ticks change nothing.
- R9: When an effective edge and a tick fall in the same cycle, the edge wins. The count is captured and reloaded with 0, and that tick is not added.
- R10: Address 0 reads the mode register with the overflow flag at bit 5. Address 1 reads the start bit. After reset every readable value, `irq` and `ovf_flag` are 0.
- R11: The measured input passes through a two-flop synchronizer before edge detection. An input change takes effect on the third rising clock edge after it is applied, and `irq` is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 mode, 1 start, 2 timer) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| meas_in | input | 1 | Asynchronous measured signal |
| tick_en | input | 4 | Count-enable strobes, one per count source |
| irq | output | 1 | One-cycle interrupt request |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach from the ports is the overflow flag together with its ageing condition. The counter needs 65,536 selected ticks with no effective edge in between. After that, a mode write before any further tick must leave the flag set, and a write after one tick must clear it. The stimulus holds the selected strobe high for exactly 65,536 cycles after the first edge. It then writes the mode register three times: once before a tick, once while stopped after a tick, and once after restarting. Edge-versus-tick priority is checked by keeping the strobe high continuously and spacing two input toggles a known number of cycles apart. The captured value then shows whether the coinciding tick was dropped.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_START = 2'd1;
  localparam logic [1:0] ADDR_TIMER = 2'd2;

  localparam logic [1:0] OP_CAPTURE = 2'b10;

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] meas;
    logic [1:0] op;
  } mode_t;

endpackage

// File: rtl/ppw_edge_sel.sv
module ppw_edge_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_in,
  input  logic [1:0] meas_sel,
  output logic       eff_edge
);
  import ppw_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= meas_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= cur;
  end

  assign rise = cur & ~last_q;
  assign fall = ~cur & last_q;

  always_comb begin
    unique case (edge_sel_e'(meas_sel))
      EDGE_FALL: eff_edge = fall;
      EDGE_RISE: eff_edge = rise;
      EDGE_BOTH: eff_edge = rise | fall;
      default:   eff_edge = 1'b0;
    endcase
  end

endmodule

// File: rtl/ppw_tick_sel.sv
module ppw_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  assign tick = tick_en[sel];
endmodule

// File: rtl/ppw_capture_core.sv
module ppw_capture_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             eff_edge,
  input  logic             tick,
  input  logic             ovf_clr_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovf_o,
  output logic             irq_o,
  output logic             fresh_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] result_q;
  logic             armed_q;
  logic             ovf_q;
  logic             aged_q;
  logic             irq_q;
  logic             fresh;
  logic             capture;
  logic             wrap;

  assign fresh   = run & ~run_prev_q;
  assign capture = run & ~fresh & eff_edge;
  assign wrap    = run & ~fresh & ~eff_edge & tick & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_prev_q <= 1'b0;
      cnt_q      <= '0;
      result_q   <= '0;
      armed_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      run_prev_q <= run;
      irq_q      <= (capture & armed_q) | wrap;
      if (fresh) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (capture) begin
        result_q <= cnt_q;
        cnt_q    <= '0;
        armed_q  <= 1'b1;
      end else if (run && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      aged_q <= 1'b0;
    end else if (wrap) begin
      ovf_q  <= 1'b1;
      aged_q <= 1'b0;
    end else if (ovf_q && aged_q && ovf_clr_req) begin
      ovf_q <= 1'b0;
    end else if (ovf_q && run && tick) begin
      aged_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;
  assign irq_o    = irq_q;
  assign fresh_o  = fresh;
  assign armed_o  = armed_q;

endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [15:0]      rd_data,
  input  logic             meas_in,
  input  logic [N_SRC-1:0] tick_en,
  output logic             irq,
  output logic             ovf_flag
);
  import ppw_pkg::*;

  mode_t            mode_q;
  logic             start_q;
  logic             run;
  logic             eff_edge;
  logic             tick;
  logic             mode_wr;
  logic             timer_wr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] result;
  logic             fresh;
  logic             armed;

  assign mode_wr  = wr_en && (wr_addr == ADDR_MODE);
  assign timer_wr = wr_en && (wr_addr == ADDR_TIMER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      start_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MODE) begin
        mode_q.src  <= wr_data[7:6];
        mode_q.meas <= wr_data[3:2];
        mode_q.op   <= wr_data[1:0];
      end
      if (wr_addr == ADDR_START) start_q <= wr_data[0];
    end
  end

  assign run = start_q && (mode_q.op == OP_CAPTURE);

  ppw_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .meas_in  (meas_in),
    .meas_sel (mode_q.meas),
    .eff_edge (eff_edge)
  );

  ppw_tick_sel #(.N_SRC(N_SRC)) u_tick (
    .tick_en (tick_en),
    .sel     (mode_q.src),
    .tick    (tick)
  );

  ppw_capture_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .eff_edge    (eff_edge),
    .tick        (tick),
    .ovf_clr_req (mode_wr & start_q),
    .cnt_o       (cnt),
    .result_o    (result),
    .ovf_o       (ovf_flag),
    .irq_o       (irq),
    .fresh_o     (fresh),
    .armed_o     (armed)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_MODE:  rd_data = {8'h00, mode_q.src, ovf_flag, 1'b0, mode_q.meas, mode_q.op};
      ADDR_START: rd_data = {15'h0000, start_q};
      ADDR_TIMER: rd_data = 16'(result);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             fresh,
  input logic             armed,
  input logic             eff_edge,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] result,
  input logic             ovf_flag,
  input logic             irq,
  input logic             mode_wr,
  input logic             start_q,
  input logic [1:0]       meas_sel
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fresh && eff_edge) |=> (result == $past(cnt) && cnt == '0)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && !fresh && eff_edge) |=> $stable(result)); // R7
  AST_NO_ILLEGAL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_sel == 2'b11) |-> !eff_edge); // R3
  AST_FIRST_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fresh && eff_edge && !armed) |=> !irq); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fresh && !eff_edge && tick && cnt == TOP) |=> (cnt == '0 && irq && ovf_flag)); // R5
  AST_OVF_CLEAR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(mode_wr && start_q)); // R6
  AST_STOPPED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R8
  AST_EDGE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fresh && eff_edge && tick) |=> (cnt == '0)); // R9
endmodule

bind pulse_capture_timer ppw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .fresh    (fresh),
  .armed    (armed),
  .eff_edge (eff_edge),
  .tick     (tick),
  .cnt      (cnt),
  .result   (result),
  .ovf_flag (ovf_flag),
  .irq      (irq),
  .mode_wr  (mode_wr),
  .start_q  (start_q),
  .meas_sel (mode_q.meas)
);

// File: tb/pulse_capture_timer_tb.sv
module pulse_capture_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        meas_in = 1'b0;
  logic [3:0]  tick_en = 4'h0;
  logic        irq;
  logic        ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pulse_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .meas_in(meas_in), .tick_en(tick_en),
    .irq(irq), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  // {edge select, count source, tick count}
  localparam logic [19:0] VEC [0:5] = '{
    {2'b00, 2'd0, 16'd5},
    {2'b01, 2'd1, 16'd12},
    {2'b10, 2'd2, 16'd7},
    {2'b00, 2'd3, 16'd1},
    {2'b01, 2'd0, 16'd0},
    {2'b10, 2'd3, 16'd40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one effective edge for the given edge select
  task automatic make_edge(input logic [1:0] m);
    if (m == 2'b10) begin
      meas_in = ~meas_in; idle(5);
    end else begin
      meas_in = (m == 2'b01); idle(5);
      meas_in = (m == 2'b00); idle(5);
    end
  endtask

  task automatic ticks(input logic [1:0] src, input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 4'b0001 << src; @(negedge clk);
      tick_en = ~(4'b0001 << src); @(negedge clk);
    end
    tick_en = 4'h0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] src);
    wr(2'd1, 16'h0);
    wr(2'd0, {8'h00, src, 2'b00, m, 2'b10});
    meas_in = (m == 2'b00); idle(5);
    wr(2'd1, 16'h1);
  endtask

  initial begin
    logic [15:0] v;
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    rd(2'd0, v); check("R10 mode reset", v, 16'h0);
    rd(2'd1, v); check("R10 start reset", v, 16'h0);
    rd(2'd2, v); check("R10 result reset", v, 16'h0);
    check("R10 irq/ovf reset", {irq, ovf_flag}, 2'b00);

    // Table: R1 R2 R3 R4 R11
    for (int k = 0; k < 6; k++) begin
      logic [1:0] m, s; logic [15:0] n;
      {m, s, n} = VEC[k];
      setup(m, s);
      base = irq_cnt;
      make_edge(m);
      check("R4 first edge silent", irq_cnt - base, 0);
      ticks(s, int'(n));
      make_edge(m);
      rd(2'd2, v);
      check("R1/R2/R3 captured count", v, n);
      check("R4 irq per edge", irq_cnt - base, 1);
    end

    // R11: capture appears after the third clock edge
    setup(2'b10, 2'd0);
    make_edge(2'b10);
    ticks(2'd0, 4);
    base = irq_cnt;
    meas_in = ~meas_in;
    @(posedge clk); @(posedge clk); #1;
    check("R11 no irq before third edge", irq, 1'b0);
    @(posedge clk); #1;
    check("R11 irq after third edge", irq, 1'b1);
    rd(2'd2, v); check("R11 result after third edge", v, 16'd4);

    // R7: timer write ignored, counter not disturbed
    wr(2'd2, 16'hBEEF);
    rd(2'd2, v); check("R7 write to timer ignored", v, 16'd4);
    make_edge(2'b10);
    ticks(2'd0, 2);
    wr(2'd2, 16'h1234);
    ticks(2'd0, 1);
    make_edge(2'b10);
    rd(2'd2, v); check("R7 counter unaffected by write", v, 16'd3);

    // R8: stopped timer ignores edges and ticks
    wr(2'd1, 16'h0);
    base = irq_cnt;
    ticks(2'd0, 5); make_edge(2'b10); ticks(2'd0, 5); make_edge(2'b10);
    rd(2'd2, v); check("R8 stopped result frozen", v, 16'd3);
    check("R8 stopped no irq", irq_cnt - base, 0);
    // R8: wrong operation mode also stops counting
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h1);
    make_edge(2'b10); ticks(2'd0, 3); make_edge(2'b10);
    rd(2'd2, v); check("R8 op field not 10 stays idle", v, 16'd3);

    // R3: edge select 11 never captures
    setup(2'b11, 2'd0);
    base = irq_cnt;
    for (int i = 0; i < 4; i++) begin meas_in = ~meas_in; ticks(2'd0, 2); idle(4); end
    rd(2'd2, v); check("R3 select 11 no capture", v, 16'd3);
    check("R3 select 11 no irq", irq_cnt - base, 0);

    // R9: tick held high, toggles 10 cycles apart -> 9
    setup(2'b10, 2'd0);
    tick_en = 4'b0001;
    meas_in = ~meas_in;
    idle(10);
    meas_in = ~meas_in;
    idle(6);
    tick_en = 4'h0;
    rd(2'd2, v); check("R9 edge beats tick", v, 16'd9);

    // R5 / R6 overflow
    setup(2'b10, 2'd0);
    make_edge(2'b10);
    base = irq_cnt;
    tick_en = 4'b0001;
    idle(65536);
    tick_en = 4'h0;
    idle(2);
    check("R5 ovf flag set", ovf_flag, 1'b1);
    check("R5 ovf irq", irq_cnt - base, 1);
    rd(2'd0, v); check("R10 ovf at bit5", v[5], 1'b1);
    wr(2'd0, 16'h0002);
    check("R6 no clear before tick", ovf_flag, 1'b1);
    ticks(2'd0, 1);
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h0002);
    check("R6 no clear while stopped", ovf_flag, 1'b1);
    wr(2'd1, 16'h1);
    wr(2'd0, 16'h0002);
    check("R6 clear after tick while running", ovf_flag, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule